// File: doc/BRIEF.md
# Video Frame Timing Generator

This block builds the horizontal and vertical timing skeleton of a serial display link that streams video. It runs on the lane byte clock. Horizontal spans (sync width, back porch, full line) are given in byte clock cycles, not pixels. Vertical regions (sync, back porch, active, front porch) are given in lines. Each cycle it reports which horizontal and vertical region is current, and it emits one-cycle strobes where syncs begin and end. It also raises a flag that tells the lane logic whether the link may drop to low power during the current blanking span.

A 2-bit mode field selects one of three video styles. Sync-pulse mode (0) marks both edges of each sync. Sync-event mode (1) and burst mode (2) mark only the starting edge. Burst mode also lets the tail of each active line go to low power. A 6-bit mask chooses, region by region, where low power is allowed.

All settings pass through a shadow stage that only loads at a frame boundary, so a frame is never torn. The block has no data stream; every pin is a plain level or strobe, sampled or produced on the rising clock edge.

Top module: `vid_frame_timer`

## Requirements
- R1: While `power_up` is low, all region flags, strobes and `lp_allow` are 0 from the next cycle on. The cycle after `power_up` is first seen high is cycle 0 of a frame: first line of vertical sync, horizontal position 0.
- R2: `hs_start` pulses in the first cycle of every line, and a line lasts exactly `cfg_line_cyc` cycles.
- R3: Within a line, `hsync_reg` is high for the first `cfg_hsync_cyc` cycles. `hback_reg` is high for the next `cfg_hback_cyc` cycles. `hrest_reg` is high for the rest of the line. Exactly one of the three is high while the block runs.
- R4: Vertical regions follow the order sync, back porch, active, front porch, then repeat. Each lasts its programmed number of lines, and a count of 0 is treated as 1 line. `vs_start` pulses in cycle 0 of the first sync line.
- R5: In mode 0, `hs_end` pulses at horizontal position `cfg_hsync_cyc` of every line. `vs_end` pulses in cycle 0 of the first vertical back porch line.
- R6: In mode 1, mode 2 and the unused code 3, `hs_end` and `vs_end` never pulse. Code 3 behaves exactly as mode 1.
- R7: `lp_allow` follows the mask. During the horizontal sync span it equals mask bit 5 in modes other than 0, and 0 in mode 0. Outside that span, on vertical sync, back porch and front porch lines it equals mask bit 0, 1 and 2 respectively. On active lines it equals bit 3 during the horizontal back porch, and bit 4 during the remainder of the line, but only in mode 2 (0 otherwise).
- R8: If `cfg_line_cyc` is not larger than `cfg_hsync_cyc + cfg_hback_cyc`, `cfg_err` is high and every flag and strobe stays 0. Settings are re-read every cycle, and the first frame starts on the cycle after a valid set is captured.
- R9: Settings (all lengths, mode and mask) are captured only at start-up and at the end of the last front porch line. A change applied mid-frame first affects the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_up | input | 1 | Run enable; low holds the generator idle |
| cfg_hsync_cyc | input | HW | Horizontal sync width, byte clock cycles |
| cfg_hback_cyc | input | HW | Horizontal back porch, byte clock cycles |
| cfg_line_cyc | input | HW | Total line length, byte clock cycles |
| cfg_vsync_lines | input | VW | Vertical sync lines |
| cfg_vback_lines | input | VW | Vertical back porch lines |
| cfg_vact_lines | input | VW | Vertical active lines |
| cfg_vfront_lines | input | VW | Vertical front porch lines |
| cfg_mode | input | 2 | 0 sync pulses, 1 sync events, 2 burst |
| cfg_lp_mask | input | 6 | Low-power permission per blanking span |
| hsync_reg | output | 1 | In horizontal sync span |
| hback_reg | output | 1 | In horizontal back porch span |
| hrest_reg | output | 1 | In active-plus-front-porch span |
| vsync_reg | output | 1 | On a vertical sync line |
| vback_reg | output | 1 | On a vertical back porch line |
| vact_reg | output | 1 | On a vertical active line |
| vfront_reg | output | 1 | On a vertical front porch line |
| hs_start | output | 1 | Strobe: line and horizontal sync begin |
| hs_end | output | 1 | Strobe: horizontal sync ends (mode 0) |
| vs_start | output | 1 | Strobe: vertical sync begins (frame start) |
| vs_end | output | 1 | Strobe: vertical sync ends (mode 0) |
| lp_allow | output | 1 | Link may enter low power now |
| cfg_err | output | 1 | Captured horizontal settings are invalid |

## Verification
A wrong horizontal counter shows at once as a flag edge or `hs_start` landing in the wrong cycle of the very first line. A wrong vertical sequencer shows at the first region boundary, within a few lines, as the wrong vertical flag or a misplaced `vs_start`/`vs_end`. A shadow register that loads at the wrong time only shows one frame later, as a line length that changes mid-frame or fails to change at the boundary. The bench therefore runs across a frame wrap. Mask and mode decoding faults show as `lp_allow` or end strobes that are wrong in specific spans. The bench compares every cycle of a whole frame against a model worked out from the requirements.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    VR_SYNC  = 2'd0,
    VR_BACK  = 2'd1,
    VR_ACT   = 2'd2,
    VR_FRONT = 2'd3
  } vreg_e;

  localparam logic [1:0] MODE_PULSE = 2'd0;
  localparam logic [1:0] MODE_BURST = 2'd2;
  localparam int         MASK_W     = 6;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow #(
  parameter int HW = 15,
  parameter int VW = 12,
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] i_hsa,
  input  logic [HW-1:0] i_hbp,
  input  logic [HW-1:0] i_hline,
  input  logic [VW-1:0] i_vsa,
  input  logic [VW-1:0] i_vbp,
  input  logic [VW-1:0] i_vact,
  input  logic [VW-1:0] i_vfp,
  input  logic [1:0]    i_mode,
  input  logic [MW-1:0] i_mask,
  output logic [HW-1:0] q_hsa,
  output logic [HW-1:0] q_hbp,
  output logic [HW-1:0] q_hline,
  output logic [VW-1:0] q_vsa,
  output logic [VW-1:0] q_vbp,
  output logic [VW-1:0] q_vact,
  output logic [VW-1:0] q_vfp,
  output logic [1:0]    q_mode,
  output logic [MW-1:0] q_mask,
  output logic          q_err
);
  localparam int SW = HW + 1;

  logic [SW-1:0] blank_sum;
  assign blank_sum = {1'b0, i_hsa} + {1'b0, i_hbp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_hsa   <= '0;
      q_hbp   <= '0;
      q_hline <= '0;
      q_vsa   <= '0;
      q_vbp   <= '0;
      q_vact  <= '0;
      q_vfp   <= '0;
      q_mode  <= '0;
      q_mask  <= '0;
      q_err   <= 1'b1;
    end else if (load) begin
      q_hsa   <= i_hsa;
      q_hbp   <= i_hbp;
      q_hline <= i_hline;
      q_vsa   <= i_vsa;
      q_vbp   <= i_vbp;
      q_vact  <= i_vact;
      q_vfp   <= i_vfp;
      q_mode  <= i_mode;
      q_mask  <= i_mask;
      q_err   <= ({1'b0, i_hline} <= blank_sum);
    end
  end

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(q_hline) && $stable(q_mode) && $stable(q_vact) && $stable(q_mask)))
    else $error("settings changed without a frame-boundary load");
endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount #(
  parameter int HW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [HW-1:0] hsa,
  input  logic [HW-1:0] hbp,
  input  logic [HW-1:0] hline,
  output logic [HW-1:0] hcnt,
  output logic          line_end,
  output logic          in_sync,
  output logic          in_back,
  output logic          in_rest
);
  localparam int SW = HW + 1;

  logic [SW-1:0] rest_pos;
  assign rest_pos = {1'b0, hsa} + {1'b0, hbp};

  assign line_end = active && (hcnt == hline - 1'b1);
  assign in_sync  = active && (hcnt < hsa);
  assign in_back  = active && !in_sync && ({1'b0, hcnt} < rest_pos);
  assign in_rest  = active && ({1'b0, hcnt} >= rest_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hcnt <= '0;
    else if (!active || line_end) hcnt <= '0;
    else                        hcnt <= hcnt + 1'b1;
  end

  p_hcnt_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (hcnt < hline))
    else $error("horizontal position beyond line length");
endmodule

// File: rtl/vtg_vseq.sv
module vtg_vseq
  import vtg_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          line_end,
  input  logic [VW-1:0] len_sync,
  input  logic [VW-1:0] len_back,
  input  logic [VW-1:0] len_act,
  input  logic [VW-1:0] len_front,
  output vreg_e         vreg,
  output logic [VW-1:0] vline,
  output logic          frame_end
);
  logic [VW-1:0] cur_len;
  logic          last_line;

  always_comb begin
    case (vreg)
      VR_SYNC: cur_len = len_sync;
      VR_BACK: cur_len = len_back;
      VR_ACT:  cur_len = len_act;
      default: cur_len = len_front;
    endcase
  end

  assign last_line = ({1'b0, vline} + {{VW{1'b0}}, 1'b1}) >= {1'b0, cur_len};
  assign frame_end = line_end && last_line && (vreg == VR_FRONT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vreg  <= VR_SYNC;
      vline <= '0;
    end else if (!active) begin
      vreg  <= VR_SYNC;
      vline <= '0;
    end else if (line_end) begin
      if (last_line) begin
        vline <= '0;
        case (vreg)
          VR_SYNC: vreg <= VR_BACK;
          VR_BACK: vreg <= VR_ACT;
          VR_ACT:  vreg <= VR_FRONT;
          default: vreg <= VR_SYNC;
        endcase
      end else begin
        vline <= vline + 1'b1;
      end
    end
  end

  p_region_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && line_end && !last_line) |=> $stable(vreg))
    else $error("vertical region left before its last line");
endmodule

// File: rtl/vid_frame_timer.sv
module vid_frame_timer
  import vtg_pkg::*;
#(
  parameter int HW = 15,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          power_up,
  input  logic [HW-1:0] cfg_hsync_cyc,
  input  logic [HW-1:0] cfg_hback_cyc,
  input  logic [HW-1:0] cfg_line_cyc,
  input  logic [VW-1:0] cfg_vsync_lines,
  input  logic [VW-1:0] cfg_vback_lines,
  input  logic [VW-1:0] cfg_vact_lines,
  input  logic [VW-1:0] cfg_vfront_lines,
  input  logic [1:0]    cfg_mode,
  input  logic [5:0]    cfg_lp_mask,
  output logic          hsync_reg,
  output logic          hback_reg,
  output logic          hrest_reg,
  output logic          vsync_reg,
  output logic          vback_reg,
  output logic          vact_reg,
  output logic          vfront_reg,
  output logic          hs_start,
  output logic          hs_end,
  output logic          vs_start,
  output logic          vs_end,
  output logic          lp_allow,
  output logic          cfg_err
);
  logic [HW-1:0]     sh_hsa, sh_hbp, sh_hline, hcnt;
  logic [VW-1:0]     sh_vsa, sh_vbp, sh_vact, sh_vfp, vline;
  logic [1:0]        sh_mode;
  logic [MASK_W-1:0] sh_mask;
  logic              sh_err, run, active, load;
  logic              line_end, frame_end, in_sync, in_back, in_rest;
  logic              is_pulse, is_burst, line_first;
  vreg_e             vreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= power_up;
  end

  assign active = run && !sh_err;
  assign load   = power_up && (!run || sh_err || frame_end);

  vtg_shadow #(.HW(HW), .VW(VW), .MW(MASK_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .i_hsa(cfg_hsync_cyc), .i_hbp(cfg_hback_cyc), .i_hline(cfg_line_cyc),
    .i_vsa(cfg_vsync_lines), .i_vbp(cfg_vback_lines),
    .i_vact(cfg_vact_lines), .i_vfp(cfg_vfront_lines),
    .i_mode(cfg_mode), .i_mask(cfg_lp_mask),
    .q_hsa(sh_hsa), .q_hbp(sh_hbp), .q_hline(sh_hline),
    .q_vsa(sh_vsa), .q_vbp(sh_vbp), .q_vact(sh_vact), .q_vfp(sh_vfp),
    .q_mode(sh_mode), .q_mask(sh_mask), .q_err(sh_err)
  );

  vtg_hcount #(.HW(HW)) u_hcount (
    .clk(clk), .rst_n(rst_n), .active(active),
    .hsa(sh_hsa), .hbp(sh_hbp), .hline(sh_hline),
    .hcnt(hcnt), .line_end(line_end),
    .in_sync(in_sync), .in_back(in_back), .in_rest(in_rest)
  );

  vtg_vseq #(.VW(VW)) u_vseq (
    .clk(clk), .rst_n(rst_n), .active(active), .line_end(line_end),
    .len_sync(sh_vsa), .len_back(sh_vbp), .len_act(sh_vact), .len_front(sh_vfp),
    .vreg(vreg), .vline(vline), .frame_end(frame_end)
  );

  assign is_pulse   = (sh_mode == MODE_PULSE);
  assign is_burst   = (sh_mode == MODE_BURST);
  assign line_first = active && (hcnt == '0);

  assign hsync_reg  = in_sync;
  assign hback_reg  = in_back;
  assign hrest_reg  = in_rest;
  assign vsync_reg  = active && (vreg == VR_SYNC);
  assign vback_reg  = active && (vreg == VR_BACK);
  assign vact_reg   = active && (vreg == VR_ACT);
  assign vfront_reg = active && (vreg == VR_FRONT);

  assign hs_start = line_first;
  assign hs_end   = is_pulse && active && (hcnt == sh_hsa);
  assign vs_start = line_first && (vreg == VR_SYNC) && (vline == '0);
  assign vs_end   = is_pulse && line_first && (vreg == VR_BACK) && (vline == '0);
  assign cfg_err  = run && sh_err;

  always_comb begin
    lp_allow = 1'b0;
    if (active) begin
      if (in_sync) begin
        lp_allow = !is_pulse && sh_mask[5];
      end else begin
        case (vreg)
          VR_SYNC: lp_allow = sh_mask[0];
          VR_BACK: lp_allow = sh_mask[1];
          VR_ACT:  lp_allow = in_back ? sh_mask[3] : (sh_mask[4] && is_burst);
          default: lp_allow = sh_mask[2];
        endcase
      end
    end
  end

  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(hsync_reg || hback_reg || hrest_reg || vsync_reg || hs_start || lp_allow))
    else $error("outputs active while powered down");

  p_one_hregion_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones({hsync_reg, hback_reg, hrest_reg}) == 1))
    else $error("horizontal regions not exclusive");

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !(hs_start || vs_start || vact_reg || lp_allow))
    else $error("timing produced with invalid settings");

  p_vs_end_on_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vs_end |-> (hs_start && vback_reg))
    else $error("vertical sync end off a line start");
endmodule

// File: tb/test_vid_frame_timer.sv
module test_vid_frame_timer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, power_up;
  logic [14:0] c_hsa, c_hbp, c_hline;
  logic [11:0] c_vsa, c_vbp, c_vact, c_vfp;
  logic [1:0]  c_mode;
  logic [5:0]  c_mask;
  logic hsync_reg, hback_reg, hrest_reg, vsync_reg, vback_reg, vact_reg, vfront_reg;
  logic hs_start, hs_end, vs_start, vs_end, lp_allow, cfg_err;

  int n_run = 0;
  int n_fail = 0;

  vid_frame_timer i_vid_frame_timer (
    .clk(clk), .rst_n(rst_n), .power_up(power_up),
    .cfg_hsync_cyc(c_hsa), .cfg_hback_cyc(c_hbp), .cfg_line_cyc(c_hline),
    .cfg_vsync_lines(c_vsa), .cfg_vback_lines(c_vbp),
    .cfg_vact_lines(c_vact), .cfg_vfront_lines(c_vfp),
    .cfg_mode(c_mode), .cfg_lp_mask(c_mask),
    .hsync_reg(hsync_reg), .hback_reg(hback_reg), .hrest_reg(hrest_reg),
    .vsync_reg(vsync_reg), .vback_reg(vback_reg), .vact_reg(vact_reg),
    .vfront_reg(vfront_reg), .hs_start(hs_start), .hs_end(hs_end),
    .vs_start(vs_start), .vs_end(vs_end), .lp_allow(lp_allow), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic int all_flags();
    return {hsync_reg, hback_reg, hrest_reg, vsync_reg, vback_reg, vact_reg,
            vfront_reg, hs_start, hs_end, vs_start, vs_end, lp_allow};
  endfunction

  task automatic set_cfg(input int hs, input int hb, input int hl, input int vs,
                         input int vb, input int va, input int vf, input int md,
                         input int mk);
    c_hsa = 15'(hs); c_hbp = 15'(hb); c_hline = 15'(hl);
    c_vsa = 12'(vs); c_vbp = 12'(vb); c_vact = 12'(va); c_vfp = 12'(vf);
    c_mode = 2'(md); c_mask = 6'(mk);
  endtask

  // power cycle; returns at the negedge of frame cycle 0
  task automatic start_run();
    power_up = 1'b0;
    @(negedge clk); @(negedge clk);
    power_up = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_cycle(input int k);
    int hl = int'(c_hline);
    int hs = int'(c_hsa);
    int hb = int'(c_hbp);
    int l0 = eff(int'(c_vsa));
    int l1 = eff(int'(c_vbp));
    int l2 = eff(int'(c_vact));
    int l3 = eff(int'(c_vfp));
    int fl = l0 + l1 + l2 + l3;
    int ln = (k / hl) % fl;
    int h  = k % hl;
    int vr, vl, hr, elp;
    bit pulse = (c_mode == 2'd0);
    bit burst = (c_mode == 2'd2);
    if (ln < l0)                begin vr = 0; vl = ln; end
    else if (ln < l0 + l1)      begin vr = 1; vl = ln - l0; end
    else if (ln < l0 + l1 + l2) begin vr = 2; vl = ln - l0 - l1; end
    else                        begin vr = 3; vl = ln - l0 - l1 - l2; end
    hr = (h < hs) ? 0 : ((h < hs + hb) ? 1 : 2);
    if (hr == 0) elp = (!pulse && c_mask[5]) ? 1 : 0;
    else if (vr == 0) elp = c_mask[0];
    else if (vr == 1) elp = c_mask[1];
    else if (vr == 3) elp = c_mask[2];
    else if (hr == 1) elp = c_mask[3];
    else elp = (c_mask[4] && burst) ? 1 : 0;
    chk("R3 hflags", {hsync_reg, hback_reg, hrest_reg}, 4 >> hr);
    chk("R4 vflags", {vsync_reg, vback_reg, vact_reg, vfront_reg}, 8 >> vr);
    chk("R4 vs_start", vs_start, (h == 0 && vr == 0 && vl == 0) ? 1 : 0);
    chk("R2 hs_start", hs_start, (h == 0) ? 1 : 0);
    if (pulse) begin
      chk("R5 hs_end", hs_end, (h == hs) ? 1 : 0);
      chk("R5 vs_end", vs_end, (h == 0 && vr == 1 && vl == 0) ? 1 : 0);
    end else begin
      chk("R6 hs_end", hs_end, 0);
      chk("R6 vs_end", vs_end, 0);
    end
    chk("R7 lp_allow", lp_allow, elp);
  endtask

  task automatic t_reset();
    chk("R1 reset quiet", all_flags(), 0);
    chk("R1 reset no err", cfg_err, 0);
  endtask

  task automatic t_frame(input int md, input int mk, input int vb);
    int total;
    set_cfg(2, 3, 10, 1, vb, 3, 1, md, mk);
    start_run();
    total = (1 + eff(vb) + 3 + 1) * 10 + 10;
    for (int k = 0; k < total; k++) begin
      check_cycle(k);
      @(negedge clk);
    end
  endtask

  task automatic t_power_cycle();
    set_cfg(2, 3, 10, 1, 2, 3, 1, 0, 6'h3f);
    start_run();
    repeat (15) @(negedge clk);
    power_up = 1'b0;
    @(negedge clk);
    chk("R1 off quiet", all_flags(), 0);
    @(negedge clk);
    chk("R1 off quiet later", all_flags(), 0);
    power_up = 1'b1;
    @(negedge clk);
    chk("R1 restart vs_start", vs_start, 1);
    chk("R1 restart sync line", {vsync_reg, hsync_reg}, 3);
  endtask

  task automatic t_bad_cfg();
    set_cfg(4, 6, 10, 1, 1, 1, 1, 0, 6'h3f);
    start_run();
    for (int k = 0; k < 5; k++) begin
      chk("R8 err flag", cfg_err, 1);
      chk("R8 quiet", all_flags(), 0);
      @(negedge clk);
    end
    c_hline = 15'd11;
    @(negedge clk);
    chk("R8 recovered err", cfg_err, 0);
    chk("R8 recovered vs_start", vs_start, 1);
  endtask

  task automatic t_frame_capture();
    set_cfg(2, 3, 10, 1, 2, 3, 1, 1, 0);
    start_run();
    for (int k = 0; k < 100; k++) begin
      int exp;
      if (k == 3) c_hline = 15'd12;
      exp = (k < 70) ? ((k % 10 == 0) ? 1 : 0) : (((k - 70) % 12 == 0) ? 1 : 0);
      chk("R9 line start", hs_start, exp);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    power_up = 1'b0;
    set_cfg(2, 3, 10, 1, 2, 3, 1, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame(0, 6'b000111, 2);
    t_frame(1, 6'b111000, 2);
    t_frame(2, 6'b110110, 0);
    t_frame(3, 6'b101010, 2);
    t_power_cycle();
    t_bad_cfg();
    t_frame_capture();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule